// File: doc/BRIEF.md
# Lock-Protected System Control Register Bank

This block is the register file of a board-level system controller. It sits on a simple 32-bit register bus and answers inside a 4 KB address window. Software reads a fixed identification word and keeps a set of volatile flags and a set of non-volatile flags. Each flag set has one address that sets the written bits and another that clears them, so no read-modify-write is needed. A reset control register can ask the platform for a system reset, but it only accepts a write after a 16-bit key has been written to the lock register.

Each request is one cycle long. The response comes back exactly one cycle later with read data and an error flag. Offsets that belong to board functions this bank does not model are accepted: writes to them are dropped and reads return zero. Any other offset, and any address that is not word aligned, is answered with an error.

There are two resets. The power-on reset `por_n` clears everything. The system reset `rst_n`, which the platform drives in response to `sys_reset_req`, clears everything except the non-volatile flags.

Top module: `sysctl_bank`

## Requirements
- R1: A write of exactly 0x0000A05F to offset 0x20 unlocks the bank. A read of 0x20 then returns 0x0000A05F, with bit 16 (locked) equal to 0.
- R2: A write of any other value to offset 0x20 stores only bits 14:0 of the data and leaves the bank locked. A read of 0x20 returns those 15 bits, with bit 16 equal to 1.
- R3: A write to 0x30 ORs the data into the volatile flags, and a write to 0x34 clears the bits that are 1 in the data. A read of 0x30 or 0x34 returns the volatile flags.
- R4: Offsets 0x38 (set) and 0x3C (clear) work the same way on the non-volatile flags, and a read of either offset returns them. The non-volatile flags keep their value through `rst_n` and are cleared only by `por_n`. The volatile flags are cleared by either reset.
- R5: A write to 0x40 while unlocked stores the data in the reset control register. If bit 8 of that data is 1, `sys_reset_req` is high for the one cycle that follows the write. While locked, a write to 0x40 changes nothing and raises no request. A read of 0x40 returns the stored value.
- R6: A read of offset 0x00 returns the parameter SYS_ID. A write to 0x00 has no effect.
- R7: Any offset outside the map, and any address whose bits 1:0 are not 00, gives a response with `rsp_err` = 1 and data 0, and changes no state.
- R8: The unmodelled offsets are 0x04–0x1C, 0x24–0x2C, 0x44–0x9C and 0xC0–0xD0, word aligned. They respond without error, read as 0, and ignore writes.
- R9: `rsp_valid` is high exactly one cycle after each accepted request. Read data reflects the state before any write in that same cycle.
- R10: After either reset the bank is locked with a stored lock value of 0, and the volatile flags and the reset control register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, synchronous, active low; keeps the non-volatile flags |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears all state |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the 4 KB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Bad offset or misaligned access |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach from the ports is a reset request. It needs a write of the exact key to the lock register, then a write to reset control with bit 8 set, and no other lock write in between. Uniform random data would almost never produce the key. The random stimulus therefore writes the exact key in a quarter of its lock writes and sets bit 8 in half of its reset control writes, so both the locked and unlocked cases come up many times. Directed sequences then pulse `rst_n` with both flag sets non-zero and check that only the non-volatile set survives, followed by a power-on reset that clears it as well.

// File: rtl/sysctl_pkg.sv
// Shared definitions for the system control register bank: word offsets,
// the decoded access kind and the lock key. Assumes a byte-addressed 4 KB window.
package sysctl_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam logic [15:0] LOCK_KEY = 16'hA05F;

    localparam logic [ADDR_W-1:0] OFF_ID      = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_LOCK    = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_FLG_SET = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_FLG_CLR = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_NV_SET  = 12'h038;
    localparam logic [ADDR_W-1:0] OFF_NV_CLR  = 12'h03C;
    localparam logic [ADDR_W-1:0] OFF_RCTL    = 12'h040;

    typedef enum logic [3:0] {
        SEL_ID,
        SEL_LOCK,
        SEL_FLG_SET,
        SEL_FLG_CLR,
        SEL_NV_SET,
        SEL_NV_CLR,
        SEL_RCTL,
        SEL_NOP,
        SEL_BAD
    } sel_e;
endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: turns a byte offset into the access kind. Assumes the
// offset is already inside the window; misaligned addresses decode as bad.
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    // Is this one of the accepted but unmodelled offsets?
    function automatic logic is_nop(input logic [ADDR_W-1:0] a);
        return ((a >= 12'h004) && (a <= 12'h02C) && (a != OFF_LOCK)) ||
               ((a >= 12'h044) && (a <= 12'h09C)) ||
               ((a >= 12'h0C0) && (a <= 12'h0D0));
    endfunction

    // Map the offset to an access kind.
    always_comb begin
        if (addr[1:0] != 2'b00) begin
            sel = SEL_BAD;
        end else begin
            unique case (addr)
                OFF_ID:      sel = SEL_ID;
                OFF_LOCK:    sel = SEL_LOCK;
                OFF_FLG_SET: sel = SEL_FLG_SET;
                OFF_FLG_CLR: sel = SEL_FLG_CLR;
                OFF_NV_SET:  sel = SEL_NV_SET;
                OFF_NV_CLR:  sel = SEL_NV_CLR;
                OFF_RCTL:    sel = SEL_RCTL;
                default:     sel = is_nop(addr) ? SEL_NOP : SEL_BAD;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_lock.sv
// Lock register: holds the last written lock value. Writing the exact key
// unlocks; any other value keeps bits 14:0 only and so stays locked.
// Assumes wr_en is a single-cycle strobe with valid wdata.
module sysctl_lock
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked,
    output logic [DATA_W-1:0] rd_value
);
    logic [15:0] lock_q;

    // Store the key in full, or only the low 15 bits of any other value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (wr_en) begin
            if (wdata == {{(DATA_W-16){1'b0}}, LOCK_KEY}) begin
                lock_q <= LOCK_KEY;
            end else begin
                lock_q <= {1'b0, wdata[14:0]};
            end
        end
    end

    // Unlock state and read view (bit 16 = locked).
    always_comb begin
        unlocked = (lock_q == LOCK_KEY);
        rd_value = {{(DATA_W-17){1'b0}}, ~unlocked, lock_q};
    end

    AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == {{(DATA_W-16){1'b0}}, LOCK_KEY}) |=> unlocked); // R1
    AST_OTHER_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata != {{(DATA_W-16){1'b0}}, LOCK_KEY}) |=>
        (!unlocked && rd_value[14:0] == $past(wdata[14:0]))); // R2
endmodule

// File: rtl/sysctl_setclr_reg.sv
// Flag register with separate set and clear strobes. Assumes set and clear
// are never strobed together (they come from distinct offsets).
module sysctl_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // OR in written ones on set, drop written ones on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (set_en) begin
            q <= q | wdata;
        end else if (clr_en) begin
            q <= q & ~wdata;
        end
    end

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(wdata)) == $past(wdata))); // R3
    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((q & $past(wdata)) == '0)); // R3
    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en)); // R3
endmodule

// File: rtl/sysctl_bank.sv
// Top of the system control register bank. Decodes one single-cycle bus
// request, updates the lock, the flags and the reset control register, and
// returns a registered response one cycle later. Assumes synchronous,
// active-low resets; por_n clears all state, rst_n all but non-volatile flags.
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] SYS_ID  = 32'h0,
    parameter int          FLAG_W  = 32,
    parameter int          RST_BIT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [11:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err,
    output logic        sys_reset_req
);
    localparam int PAD_W = DATA_W - FLAG_W;

    sel_e              sel;
    logic              sys_rst_n;
    logic              wr;
    logic              unlocked;
    logic [DATA_W-1:0] lock_rd;
    logic [FLAG_W-1:0] flg_q;
    logic [FLAG_W-1:0] nv_q;
    logic [DATA_W-1:0] rctl_q;
    logic [DATA_W-1:0] rd_mux;

    // Combined reset for state that the system reset clears.
    always_comb begin
        sys_rst_n = rst_n && por_n;
        wr        = req_valid && req_write;
    end

    sysctl_decode u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    sysctl_lock u_lock (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .wr_en    (wr && sel == SEL_LOCK),
        .wdata    (req_wdata),
        .unlocked (unlocked),
        .rd_value (lock_rd)
    );

    sysctl_setclr_reg #(.W(FLAG_W)) u_flags (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .set_en (wr && sel == SEL_FLG_SET),
        .clr_en (wr && sel == SEL_FLG_CLR),
        .wdata  (req_wdata[FLAG_W-1:0]),
        .q      (flg_q)
    );

    sysctl_setclr_reg #(.W(FLAG_W)) u_nvflags (
        .clk    (clk),
        .rst_n  (por_n),
        .set_en (wr && sel == SEL_NV_SET),
        .clr_en (wr && sel == SEL_NV_CLR),
        .wdata  (req_wdata[FLAG_W-1:0]),
        .q      (nv_q)
    );

    // Reset control register and its one-shot request, gated by the lock.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            rctl_q        <= '0;
            sys_reset_req <= 1'b0;
        end else begin
            sys_reset_req <= 1'b0;
            if (wr && sel == SEL_RCTL && unlocked) begin
                rctl_q        <= req_wdata;
                sys_reset_req <= req_wdata[RST_BIT];
            end
        end
    end

    // Read data selection for the current request.
    always_comb begin
        unique case (sel)
            SEL_ID:                  rd_mux = SYS_ID;
            SEL_LOCK:                rd_mux = lock_rd;
            SEL_FLG_SET, SEL_FLG_CLR: rd_mux = {{PAD_W{1'b0}}, flg_q};
            SEL_NV_SET, SEL_NV_CLR:  rd_mux = {{PAD_W{1'b0}}, nv_q};
            SEL_RCTL:                rd_mux = rctl_q;
            default:                 rd_mux = '0;
        endcase
    end

    // Registered response one cycle after each request.
    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && (sel == SEL_BAD);
            rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
        end
    end

    AST_RST_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!sys_rst_n)
        sys_reset_req |-> $past(unlocked)); // R5
    AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!sys_rst_n)
        sys_reset_req |-> $past(req_valid && req_write && req_addr == OFF_RCTL
                                && req_wdata[RST_BIT])); // R5
    AST_LOCKED_RCTL_HOLD: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (req_valid && req_write && req_addr == OFF_RCTL && !unlocked) |=>
        ($stable(rctl_q) && !sys_reset_req)); // R5
    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!sys_rst_n)
        req_valid |=> rsp_valid); // R9
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!sys_rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R7
    AST_NV_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && !(req_valid && req_write)) |=> $stable(nv_q)); // R4
endmodule

// File: tb/sysctl_bank_test.sv
// Self-checking bench for sysctl_bank: seeded random accesses plus directed
// corner cases, checked against a bench-side model of the register map.
module sysctl_bank_test;
    logic        clk = 1'b0;
    logic        rst_n, por_n;
    logic        req_valid, req_write;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid, rsp_err, sys_reset_req;
    logic [31:0] rsp_rdata;

    localparam logic [31:0] ID_VAL = 32'h1234_5678;

    sysctl_bank #(.SYS_ID(ID_VAL)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .por_n         (por_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_err       (rsp_err),
        .sys_reset_req (sys_reset_req)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    // Bench model of the register state.
    logic [15:0] m_lock;
    logic [31:0] m_flg, m_nv, m_rctl;

    always @(posedge clk) cycles <= cycles + 1;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cycles > 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Accepted but unmodelled offsets (R8).
    function automatic logic is_nop(input logic [11:0] a);
        return a[1:0] == 2'b00 &&
               (((a >= 12'h004) && (a <= 12'h02C) && (a != 12'h020)) ||
                ((a >= 12'h044) && (a <= 12'h09C)) ||
                ((a >= 12'h0C0) && (a <= 12'h0D0)));
    endfunction

    function automatic logic is_reg(input logic [11:0] a);
        return a == 12'h000 || a == 12'h020 || a == 12'h030 || a == 12'h034 ||
               a == 12'h038 || a == 12'h03C || a == 12'h040;
    endfunction

    function automatic logic m_unlocked();
        return m_lock == 16'hA05F;
    endfunction

    // Expected read data from the model (R1 R2 R3 R4 R5 R6 R8).
    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            12'h000:          return ID_VAL;
            12'h020:          return {15'b0, !m_unlocked(), m_lock};
            12'h030, 12'h034: return m_flg;
            12'h038, 12'h03C: return m_nv;
            12'h040:          return m_rctl;
            default:          return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        if (!is_reg(a) && !is_nop(a)) return "R7";
        case (a)
            12'h000:          return "R6";
            12'h020:          return "R2";
            12'h030, 12'h034: return "R3";
            12'h038, 12'h03C: return "R4";
            12'h040:          return "R5";
            default:          return "R8";
        endcase
    endfunction

    // One access: drive on a falling edge, check the response one cycle later.
    task automatic do_op(input logic wr_i, input logic [11:0] a, input logic [31:0] d);
        logic [31:0] e_data;
        logic        e_err, e_pulse;
        string       t;
        t       = tag_of(a);
        e_err   = !(is_reg(a) || is_nop(a));
        e_data  = (wr_i || e_err) ? 32'h0 : exp_read(a);
        e_pulse = wr_i && a == 12'h040 && m_unlocked() && d[8];
        @(negedge clk);
        req_valid = 1'b1; req_write = wr_i; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check({t, " R9 rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
        check({t, " err"}, {31'b0, rsp_err}, {31'b0, e_err});
        check({t, " rdata"}, rsp_rdata, e_data);
        check("R5 sys_reset_req", {31'b0, sys_reset_req}, {31'b0, e_pulse});
        if (wr_i && !e_err) begin
            case (a)
                12'h020: m_lock = (d == 32'h0000A05F) ? 16'hA05F : {1'b0, d[14:0]};
                12'h030: m_flg  = m_flg | d;
                12'h034: m_flg  = m_flg & ~d;
                12'h038: m_nv   = m_nv | d;
                12'h03C: m_nv   = m_nv & ~d;
                12'h040: if (m_unlocked()) m_rctl = d;
                default: ;
            endcase
        end
    endtask

    task automatic apply_reset(input logic por);
        @(negedge clk);
        rst_n = 1'b0;
        if (por) por_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        m_lock = 16'h0; m_flg = 32'h0; m_rctl = 32'h0;
        if (por) m_nv = 32'h0;
    endtask

    initial begin
        logic [11:0] a;
        logic [31:0] d;
        void'($urandom(32'd2024));
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        rst_n = 1; por_n = 1;
        m_nv = 32'h0;
        apply_reset(1'b1);

        // R10: reset state
        check("R10 rsp_valid idle", {31'b0, rsp_valid}, 32'd0);
        do_op(0, 12'h020, 0);
        do_op(0, 12'h030, 0);
        do_op(0, 12'h040, 0);
        check("R10 lock state", {15'b0, !m_unlocked(), m_lock}, 32'h0001_0000);

        // R6: ID read, write ignored
        do_op(1, 12'h000, 32'hFFFF_FFFF);
        do_op(0, 12'h000, 0);

        // R5: locked write to reset control has no effect
        do_op(1, 12'h040, 32'h0000_0100);
        do_op(0, 12'h040, 0);

        // R1 then R5: unlock, request reset
        do_op(1, 12'h020, 32'h0000_A05F);
        do_op(0, 12'h020, 0);
        do_op(1, 12'h040, 32'h0000_0155);
        do_op(0, 12'h040, 0);

        // R2: key in upper bits / near miss relocks
        do_op(1, 12'h020, 32'h0001_A05F);
        do_op(0, 12'h020, 0);
        do_op(1, 12'h040, 32'h0000_0100);

        // R7: misaligned and out-of-map accesses
        do_op(1, 12'h031, 32'hFFFF_FFFF);
        do_op(0, 12'h030, 0);
        do_op(0, 12'hFFC, 0);
        do_op(1, 12'h0A0, 32'h1);

        // R8: unmodelled offsets
        do_op(1, 12'h09C, 32'hDEAD_BEEF);
        do_op(0, 12'h09C, 0);
        do_op(0, 12'h0D0, 0);

        // R3/R4 then system reset: only non-volatile flags survive
        do_op(1, 12'h030, 32'hF0F0_0F0F);
        do_op(1, 12'h034, 32'h3000_0003);
        do_op(1, 12'h038, 32'h8000_0001);
        do_op(0, 12'h030, 0);
        apply_reset(1'b0);
        do_op(0, 12'h034, 0);
        do_op(0, 12'h03C, 0);
        apply_reset(1'b1);
        do_op(0, 12'h038, 0);

        // Seeded random mix biased toward the lock key and reset bit.
        for (int i = 0; i < 400; i++) begin
            int unsigned pick;
            pick = $urandom_range(0, 11);
            case (pick)
                0: a = 12'h000;  1: a = 12'h020;  2: a = 12'h030;
                3: a = 12'h034;  4: a = 12'h038;  5: a = 12'h03C;
                6, 7: a = 12'h040;
                8: a = 12'h004 + 12'($urandom_range(0, 50) * 4);
                9: a = 12'($urandom_range(0, 4095));
                10: a = 12'h020;
                default: a = 12'h0C0 + 12'($urandom_range(0, 4) * 4);
            endcase
            d = $urandom();
            if (a == 12'h020 && $urandom_range(0, 3) == 0) d = 32'h0000_A05F;
            if (a == 12'h040 && $urandom_range(0, 1) == 0) d[8] = 1'b1;
            do_op(1'($urandom_range(0, 1)), a, d);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule